// File: doc/BRIEF.md
# Receive Ring DMA Engine

This block takes packets arriving one byte per cycle and places them into receive buffers in system memory. Software describes those buffers through a ring of slots in memory. Each slot is 8 bytes: a buffer pointer in the first 32-bit word and a buffer size in the second word. The engine owns the producer index (head) and software owns the consumer index (tail). For each packet the engine reads the slot at head, writes the payload bytes into that buffer, stores the received byte count in the slot's size word, and steps head forward.

A small register file configures the engine. It is addressed by word index. Some settings are reached indirectly: software first writes a command code into the command register, then writes or reads the data register. If the ring has no free slot, an incoming packet is consumed and counted as dropped. A level interrupt tells software that filled slots are waiting.

Top module: `rx_ring_dma`

## Requirements
- R1: Registers are 32 bits wide and selected by word index `reg_addr_i` (byte offset / 4): 0 command, 1 data, 2 ring base address, 3 capacity in slots, 4 head, 5 tail. All of them read zero after reset. The command, base and tail registers read back what was written. A capacity write above MAX_SLOTS reads back as MAX_SLOTS. Writes to head are ignored.
- R2: Writing the data register applies the current command. Command code 1 sets power, code 2 sets interrupt enable and code 3 sets receive enable, each to data bit 0. Reading the data register under codes 1 to 3 returns that enable. Under any code other than 1 to 4 it returns zero.
- R3: Reading the data register under command code 4 returns the number of packets dropped since reset.
- R4: For each accepted packet the engine reads the word at base + 8*head (buffer address), then the word at base + 8*head + 4 (buffer size).
- R5: Payload byte i is written to byte address buffer + i. It uses exactly one byte enable, the lane given by address bits [1:0], with the byte copied to all four lanes of `mem_wdata_o`.
- R6: Only the first min(buffer size, MAX_FRAME) bytes are stored. Later bytes of the packet are accepted and discarded.
- R7: On the cycle after the last byte, the stored byte count is written as a full word (byte enables 4'hF) to base + 8*head + 4. Head then becomes (head+1) mod capacity.
- R8: With receive and power on, the ring counts as full when capacity < 2 or (head+1) mod capacity equals tail. A packet arriving then is consumed without any memory access, head is unchanged, and the drop count increases by one.
- R9: While power or receive enable is off, a packet is consumed with no memory access, no head change and no drop count change.
- R10: `irq_o` is high exactly when power, interrupt enable and receive enable are all set and head differs from tail.
- R11: `rx_ready_o` is low from the end of a packet until the next packet has been classified. The engine never reads and writes memory in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` (combinational) |
| rx_valid_i | input | 1 | Packet byte valid |
| rx_data_i | input | 8 | Packet byte |
| rx_last_i | input | 1 | Marks the final byte of a packet |
| rx_ready_o | output | 1 | Byte accepted on this edge when high with valid |
| mem_rd_o | output | 1 | Memory word read request |
| mem_raddr_o | output | 32 | Read byte address (word aligned) |
| mem_rvalid_i | input | 1 | Read data returned |
| mem_rdata_i | input | 32 | Read data |
| mem_wr_o | output | 1 | Memory write |
| mem_waddr_o | output | 32 | Write byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_wbe_o | output | 4 | Write byte enables |
| irq_o | output | 1 | Level interrupt |

## Verification
The checker enforces several rules on every cycle:
- No cycle carries both a memory read and a memory write.
- A payload write has a single byte enable.
- The end of a stored packet is followed directly by a full-word count write.
- Head moves only by one step or by wrapping to zero.
- The drop counter moves only by one.
- The interrupt is never raised while the ring is empty.

Other properties can only be shown by the bench's scenarios:
- The correct slot address and buffer contents.
- Truncation to the buffer size and to the 4000-byte limit.
- The exact moment the ring fills, and the wrap of head.
- Which packets are discarded when power or receive is off.
- The command and data register decode.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  typedef enum logic [2:0] {
    RG_CMD  = 3'd0,
    RG_DATA = 3'd1,
    RG_BASE = 3'd2,
    RG_CAP  = 3'd3,
    RG_HEAD = 3'd4,
    RG_TAIL = 3'd5
  } reg_idx_e;

  localparam logic [31:0] CMD_POWER = 32'd1;
  localparam logic [31:0] CMD_IRQEN = 32'd2;
  localparam logic [31:0] CMD_RXEN  = 32'd3;
  localparam logic [31:0] CMD_DROPS = 32'd4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RQ_A,
    ST_WT_A,
    ST_RQ_L,
    ST_WT_L,
    ST_FILL,
    ST_WB,
    ST_SINK
  } eng_state_e;
endpackage

// File: rtl/rx_ring_regs.sv
module rx_ring_regs
  import rx_ring_pkg::*;
#(
  parameter int unsigned MAX_SLOTS = 16,
  parameter int unsigned IDX_W     = 4,
  parameter int unsigned CAP_W     = 5,
  parameter int unsigned CNT_W     = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [2:0]       addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic [IDX_W-1:0] head_i,
  input  logic             drop_inc_i,
  output logic [31:0]      base_o,
  output logic [CAP_W-1:0] cap_o,
  output logic [IDX_W-1:0] tail_o,
  output logic             power_o,
  output logic             irq_en_o,
  output logic             rx_en_o,
  output logic [CNT_W-1:0] drop_o
);
  logic [31:0] cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q    <= '0;
      base_o   <= '0;
      cap_o    <= '0;
      tail_o   <= '0;
      power_o  <= 1'b0;
      irq_en_o <= 1'b0;
      rx_en_o  <= 1'b0;
      drop_o   <= '0;
    end else begin
      if (drop_inc_i) drop_o <= drop_o + CNT_W'(1);
      if (wr_i) begin
        case (addr_i)
          RG_CMD:  cmd_q  <= wdata_i;
          RG_BASE: base_o <= wdata_i;
          RG_CAP:  cap_o  <= (wdata_i > 32'(MAX_SLOTS)) ? CAP_W'(MAX_SLOTS)
                                                         : wdata_i[CAP_W-1:0];
          RG_TAIL: tail_o <= wdata_i[IDX_W-1:0];
          RG_DATA: begin
            if (cmd_q == CMD_POWER) power_o  <= wdata_i[0];
            if (cmd_q == CMD_IRQEN) irq_en_o <= wdata_i[0];
            if (cmd_q == CMD_RXEN)  rx_en_o  <= wdata_i[0];
          end
          default: ;
        endcase
      end
    end
  end

  logic [31:0] data_rd;
  always_comb begin
    case (cmd_q)
      CMD_POWER: data_rd = {31'b0, power_o};
      CMD_IRQEN: data_rd = {31'b0, irq_en_o};
      CMD_RXEN:  data_rd = {31'b0, rx_en_o};
      CMD_DROPS: data_rd = 32'(drop_o);
      default:   data_rd = '0;
    endcase
  end

  always_comb begin
    case (addr_i)
      RG_CMD:  rdata_o = cmd_q;
      RG_DATA: rdata_o = data_rd;
      RG_BASE: rdata_o = base_o;
      RG_CAP:  rdata_o = 32'(cap_o);
      RG_HEAD: rdata_o = 32'(head_i);
      RG_TAIL: rdata_o = 32'(tail_o);
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/rx_ring_engine.sv
module rx_ring_engine
  import rx_ring_pkg::*;
#(
  parameter int unsigned MAX_FRAME = 4000,
  parameter int unsigned IDX_W     = 4,
  parameter int unsigned CAP_W     = 5,
  parameter int unsigned LEN_W     = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [31:0]      base_i,
  input  logic [CAP_W-1:0] cap_i,
  input  logic [IDX_W-1:0] tail_i,
  input  logic             active_i,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_data_i,
  input  logic             rx_last_i,
  output logic             rx_ready_o,
  output logic             mem_rd_o,
  output logic [31:0]      mem_raddr_o,
  input  logic             mem_rvalid_i,
  input  logic [31:0]      mem_rdata_i,
  output logic             mem_wr_o,
  output logic [31:0]      mem_waddr_o,
  output logic [31:0]      mem_wdata_o,
  output logic [3:0]       mem_wbe_o,
  output logic [IDX_W-1:0] head_o,
  output logic             drop_o,
  output logic             fill_o
);
  eng_state_e       st_q;
  logic [31:0]      buf_q;
  logic [LEN_W-1:0] lim_q, cnt_q;
  logic [IDX_W-1:0] head_nxt;
  logic             ring_full, room;
  logic [31:0]      slot_addr, pay_addr;

  assign head_nxt  = ((CAP_W'(head_o) + CAP_W'(1)) == cap_i) ? '0 : head_o + IDX_W'(1);
  assign ring_full = (cap_i < CAP_W'(2)) || (head_nxt == tail_i);
  assign slot_addr = base_i + 32'({head_o, 3'b000});
  assign pay_addr  = buf_q + 32'(cnt_q);
  assign room      = cnt_q < lim_q;
  assign fill_o    = (st_q == ST_FILL);
  assign drop_o    = (st_q == ST_IDLE) && rx_valid_i && active_i && ring_full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      head_o <= '0;
      buf_q  <= '0;
      lim_q  <= '0;
      cnt_q  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (rx_valid_i) st_q <= (!active_i || ring_full) ? ST_SINK : ST_RQ_A;
        ST_RQ_A: st_q <= ST_WT_A;
        ST_WT_A: if (mem_rvalid_i) begin
          buf_q <= mem_rdata_i;
          st_q  <= ST_RQ_L;
        end
        ST_RQ_L: st_q <= ST_WT_L;
        ST_WT_L: if (mem_rvalid_i) begin
          lim_q <= (mem_rdata_i > 32'(MAX_FRAME)) ? LEN_W'(MAX_FRAME) : mem_rdata_i[LEN_W-1:0];
          cnt_q <= '0;
          st_q  <= ST_FILL;
        end
        ST_FILL: if (rx_valid_i) begin
          if (room) cnt_q <= cnt_q + LEN_W'(1);
          if (rx_last_i) st_q <= ST_WB;
        end
        ST_WB: begin
          head_o <= head_nxt;
          st_q   <= ST_IDLE;
        end
        ST_SINK: if (rx_valid_i && rx_last_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    rx_ready_o  = (st_q == ST_FILL) || (st_q == ST_SINK);
    mem_rd_o    = (st_q == ST_RQ_A) || (st_q == ST_RQ_L);
    mem_raddr_o = (st_q == ST_RQ_L) ? slot_addr + 32'd4 : slot_addr;
    mem_wr_o    = 1'b0;
    mem_waddr_o = pay_addr;
    mem_wdata_o = {4{rx_data_i}};
    mem_wbe_o   = 4'b0001 << pay_addr[1:0];
    if (st_q == ST_FILL) begin
      mem_wr_o = rx_valid_i && room;
    end else if (st_q == ST_WB) begin
      mem_wr_o    = 1'b1;
      mem_waddr_o = slot_addr + 32'd4;
      mem_wdata_o = 32'(cnt_q);
      mem_wbe_o   = 4'hF;
    end
  end
endmodule

// File: rtl/rx_ring_dma.sv
module rx_ring_dma #(
  parameter int unsigned MAX_SLOTS = 16,
  parameter int unsigned MAX_FRAME = 4000,
  parameter int unsigned CNT_W     = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_wr_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_data_i,
  input  logic        rx_last_i,
  output logic        rx_ready_o,
  output logic        mem_rd_o,
  output logic [31:0] mem_raddr_o,
  input  logic        mem_rvalid_i,
  input  logic [31:0] mem_rdata_i,
  output logic        mem_wr_o,
  output logic [31:0] mem_waddr_o,
  output logic [31:0] mem_wdata_o,
  output logic [3:0]  mem_wbe_o,
  output logic        irq_o
);
  localparam int unsigned IDX_W = $clog2(MAX_SLOTS);
  localparam int unsigned CAP_W = $clog2(MAX_SLOTS + 1);
  localparam int unsigned LEN_W = $clog2(MAX_FRAME + 1);

  logic [31:0]      base_w;
  logic [CAP_W-1:0] cap_w;
  logic [IDX_W-1:0] head_w, tail_w;
  logic             power_w, irq_en_w, rx_en_w, drop_w, fill_w;
  logic [CNT_W-1:0] drops_w;

  rx_ring_regs #(
    .MAX_SLOTS(MAX_SLOTS), .IDX_W(IDX_W), .CAP_W(CAP_W), .CNT_W(CNT_W)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .head_i(head_w),
    .drop_inc_i(drop_w), .base_o(base_w), .cap_o(cap_w), .tail_o(tail_w),
    .power_o(power_w), .irq_en_o(irq_en_w), .rx_en_o(rx_en_w), .drop_o(drops_w)
  );

  rx_ring_engine #(
    .MAX_FRAME(MAX_FRAME), .IDX_W(IDX_W), .CAP_W(CAP_W), .LEN_W(LEN_W)
  ) u_eng (
    .clk_i(clk_i), .rst_ni(rst_ni), .base_i(base_w), .cap_i(cap_w),
    .tail_i(tail_w), .active_i(power_w && rx_en_w),
    .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i), .rx_last_i(rx_last_i),
    .rx_ready_o(rx_ready_o), .mem_rd_o(mem_rd_o), .mem_raddr_o(mem_raddr_o),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
    .mem_wr_o(mem_wr_o), .mem_waddr_o(mem_waddr_o), .mem_wdata_o(mem_wdata_o),
    .mem_wbe_o(mem_wbe_o), .head_o(head_w), .drop_o(drop_w), .fill_o(fill_w)
  );

  assign irq_o = power_w && irq_en_w && rx_en_w && (head_w != tail_w);
endmodule

// File: rtl/rx_ring_dma_chk.sv
module rx_ring_dma_chk #(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rx_valid_i,
  input logic             rx_ready_o,
  input logic             rx_last_i,
  input logic             mem_rd_o,
  input logic             mem_wr_o,
  input logic [3:0]       mem_wbe_o,
  input logic             irq_o,
  input logic [IDX_W-1:0] head_i,
  input logic [IDX_W-1:0] tail_i,
  input logic [CNT_W-1:0] drop_i,
  input logic             fill_i
);
  AST_ONE_MEM_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o)); // R11
  AST_FRAME_END_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_ready_o && rx_last_i) |=> !rx_ready_o); // R11
  AST_BYTE_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o && mem_wbe_o != 4'hF) |-> ($countones(mem_wbe_o) == 1)); // R5
  AST_COUNT_WRITEBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && rx_valid_i && rx_ready_o && rx_last_i) |=> (mem_wr_o && mem_wbe_o == 4'hF)); // R7
  AST_HEAD_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(head_i) |-> (head_i == '0 || head_i == $past(head_i) + IDX_W'(1))); // R7
  AST_DROP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(drop_i) |-> (drop_i == $past(drop_i) + CNT_W'(1))); // R8
  AST_IRQ_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (head_i != tail_i)); // R10
endmodule

bind rx_ring_dma rx_ring_dma_chk #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rx_valid_i(rx_valid_i), .rx_ready_o(rx_ready_o),
  .rx_last_i(rx_last_i), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
  .mem_wbe_o(mem_wbe_o), .irq_o(irq_o), .head_i(head_w), .tail_i(tail_w),
  .drop_i(drops_w), .fill_i(fill_w)
);

// File: tb/rx_ring_dma_bench.sv
module rx_ring_dma_bench;
  localparam int BASE = 32'h100;
  localparam int CAP  = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        reg_wr = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        rx_valid = 0, rx_last = 0, rx_ready;
  logic [7:0]  rx_data = 0;
  logic        mem_rd, mem_wr, mem_rvalid = 0, irq;
  logic [31:0] mem_raddr, mem_rdata = 0, mem_waddr, mem_wdata;
  logic [3:0]  mem_wbe;

  rx_ring_dma u_rx_ring_dma (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .rx_valid_i(rx_valid),
    .rx_data_i(rx_data), .rx_last_i(rx_last), .rx_ready_o(rx_ready),
    .mem_rd_o(mem_rd), .mem_raddr_o(mem_raddr), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata), .mem_wr_o(mem_wr), .mem_waddr_o(mem_waddr),
    .mem_wdata_o(mem_wdata), .mem_wbe_o(mem_wbe), .irq_o(irq)
  );

  logic [7:0]  mem [0:8191];
  logic [31:0] rd_log0 = 0, rd_log1 = 0;
  int          wr_count = 0;

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_rd) begin
      mem_rvalid <= 1'b1;
      mem_rdata  <= {mem[mem_raddr[12:0]+3], mem[mem_raddr[12:0]+2],
                     mem[mem_raddr[12:0]+1], mem[mem_raddr[12:0]]};
      rd_log0 <= rd_log1;
      rd_log1 <= mem_raddr;
    end
    if (mem_wr) begin
      wr_count <= wr_count + 1;
      for (int b = 0; b < 4; b++)
        if (mem_wbe[b]) mem[{mem_waddr[12:2], 2'b00} + 13'(b)] <= mem_wdata[8*b +: 8];
    end
  end

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic reg_w(int idx, int val);
    reg_wr = 1; reg_addr = 3'(idx); reg_wdata = val;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic reg_r(int idx, output int val);
    reg_addr = 3'(idx);
    #1 val = reg_rdata;
    @(negedge clk);
  endtask

  task automatic cmd_w(int code, int val);
    reg_w(0, code); reg_w(1, val);
  endtask

  task automatic cmd_r(int code, output int val);
    reg_w(0, code); reg_r(1, val);
  endtask

  task automatic put_word(int a, int w);
    for (int b = 0; b < 4; b++) mem[a+b] = w[8*b +: 8];
  endtask

  function automatic int get_word(int a);
    return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
  endfunction

  function automatic logic [7:0] pat(int seed, int i);
    return 8'(seed + i * 3);
  endfunction

  task automatic prep_slot(int s, int buf_addr, int buf_len, int span);
    put_word(BASE + 8*s, buf_addr);
    put_word(BASE + 8*s + 4, buf_len);
    for (int i = 0; i < span; i++) mem[buf_addr+i] = 8'hEE;
  endtask

  task automatic send_frame(int len, int seed);
    for (int i = 0; i < len; i++) begin
      bit got = 0;
      rx_valid = 1; rx_data = pat(seed, i); rx_last = (i == len - 1);
      while (!got) begin
        #1 got = rx_ready;
        @(negedge clk);
      end
    end
    rx_valid = 0; rx_last = 0;
    repeat (6) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int v, h, drops, wc;
    int lens [12] = '{1, 2, 3, 4, 5, 7, 8, 9, 16, 33, 63, 64};
    for (int i = 0; i < 8192; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    for (int r = 0; r < 6; r++) begin
      reg_r(r, v); chk($sformatf("R1 reset reg %0d", r), v, 0);
    end
    chk("R10 reset irq", irq, 0);
    chk("R11 reset ready", rx_ready, 0);

    reg_w(2, BASE); reg_r(2, v); chk("R1 base readback", v, BASE);
    reg_w(3, 20);   reg_r(3, v); chk("R1 cap clip", v, 16);
    reg_w(4, 3);    reg_r(4, v); chk("R1 head write ignored", v, 0);
    reg_w(0, 9);    reg_r(0, v); chk("R1 cmd readback", v, 9);
    reg_r(1, v);    chk("R2 unknown cmd reads zero", v, 0);
    reg_w(1, 1);    cmd_r(1, v); chk("R2 data write under unknown cmd ignored", v, 0);
    cmd_w(1, 1); cmd_r(1, v); chk("R2 power on", v, 1);
    cmd_w(2, 1); cmd_r(2, v); chk("R2 irq enable", v, 1);
    cmd_w(3, 1); cmd_r(3, v); chk("R2 rx enable", v, 1);
    cmd_w(3, 0); cmd_r(3, v); chk("R2 rx disable", v, 0);
    cmd_w(3, 1);
    cmd_r(4, v); chk("R3 drops at start", v, 0);
    reg_w(3, CAP);

    // sweep of frame lengths and buffer sizes across the ring
    h = 0;
    for (int k = 0; k < 12; k++) begin
      int bl, exp_n, buf_a, bad;
      bl = (k % 3 == 0) ? 8 : 64;
      buf_a = 32'h400 + 32'h100 * h;
      reg_w(5, h);
      prep_slot(h, buf_a, bl, 128);
      send_frame(lens[k], k * 17);
      exp_n = (lens[k] < bl) ? lens[k] : bl;
      chk($sformatf("R4 desc addr read k%0d", k), rd_log0, BASE + 8*h);
      chk($sformatf("R4 desc len read k%0d", k), rd_log1, BASE + 8*h + 4);
      bad = 0;
      for (int i = 0; i < exp_n; i++) if (mem[buf_a+i] != pat(k*17, i)) bad++;
      chk($sformatf("R5 payload bytes k%0d", k), bad, 0);
      chk($sformatf("R6 no write past limit k%0d", k), mem[buf_a+exp_n], 8'hEE);
      chk($sformatf("R7 length word k%0d", k), get_word(BASE + 8*h + 4), exp_n);
      h = (h + 1) % CAP;
      reg_r(4, v); chk($sformatf("R7 head advance k%0d", k), v, h);
      chk($sformatf("R10 irq pending k%0d", k), irq, 1);
    end

    reg_w(5, h); #1 chk("R10 irq clear when empty", irq, 0);
    @(negedge clk);

    // fill the ring: tail = h, three frames fit, fourth drops
    for (int j = 0; j < 3; j++) begin
      int s;
      s = (h + j) % CAP;
      prep_slot(s, 32'h400 + 32'h100 * s, 64, 64);
      send_frame(5, 100 + j);
    end
    reg_r(4, v); chk("R7 head after three", v, (h + 3) % CAP);
    wc = wr_count;
    send_frame(6, 200);
    reg_r(4, v); chk("R8 head held when full", v, (h + 3) % CAP);
    chk("R8 no memory write when full", wr_count, wc);
    cmd_r(4, drops); chk("R3 R8 drop count", drops, 1);

    // free one slot, wrap head
    reg_w(5, (h + 1) % CAP);
    prep_slot((h + 3) % CAP, 32'h400 + 32'h100 * ((h + 3) % CAP), 64, 64);
    send_frame(4, 50);
    reg_r(4, v); chk("R7 head wraps", v, h);
    chk("R7 wrapped length word", get_word(BASE + 8*((h + 3) % CAP) + 4), 4);

    // disabled receive / power
    reg_w(5, (h + 2) % CAP);
    cmd_w(3, 0);
    #1 chk("R10 irq gated by rx enable", irq, 0);
    wc = wr_count;
    send_frame(7, 60);
    reg_r(4, v); chk("R9 head held rx off", v, h);
    chk("R9 no write rx off", wr_count, wc);
    cmd_w(3, 1); cmd_w(1, 0);
    send_frame(3, 61);
    reg_r(4, v); chk("R9 head held power off", v, h);
    cmd_r(4, v); chk("R9 drops unchanged", v, drops);
    cmd_w(1, 1);
    #1 chk("R10 irq restored", irq, 1);
    @(negedge clk);
    cmd_w(2, 0);
    #1 chk("R10 irq gated by irq enable", irq, 0);
    @(negedge clk);
    cmd_w(2, 1);

    // capacity one always full
    reg_w(3, 1); reg_w(5, 0);
    send_frame(2, 70);
    cmd_r(4, v); chk("R8 cap one drops", v, drops + 1);
    reg_r(4, v); chk("R8 cap one head held", v, h);

    // max frame truncation
    reg_w(3, CAP); reg_w(5, h);
    prep_slot(h, 32'h1000, 5000, 4010);
    send_frame(4005, 9);
    chk("R6 max frame length word", get_word(BASE + 8*h + 4), 4000);
    chk("R6 last stored byte", mem[32'h1000 + 3999], pat(9, 3999));
    chk("R6 byte past max untouched", mem[32'h1000 + 4000], 8'hEE);

    finish_run();
  end
endmodule